// File: doc/BRIEF.md
# Tick-Driven Rate Counter Readout Sequencer

This block decides which detector-card rate counters are read, and in what order, each time a periodic timing tick arrives. The 16 kHz tick reads a small set of cards. The 4 kHz tick reads a larger set, and the 1 kHz tick reads every card. For each card it raises a request toward the bus arbiter. It presents the card number, a register select and a read-width flag, and it holds them until the arbiter grants the cycle.

A telemetry cycle spans a set number of 1 kHz readouts. After the last of these, the sequencer appends a fixed run of twelve status-register reads. These cover cards 0 to 8 and then cards 0, 1 and 2 again. A sync marker for the downstream packet formatter goes with the first read after any completed 1 kHz readout. Every transfer carries the rate-data type code. An enable bit and a downstream busy input can both stop collection.

Top module: `rate_readout_seq`

## Requirements
- R1: A 16 kHz tick alone causes counter reads (reg_sel=0) of cards 0, 1, 2 in ascending order, and nothing else.
- R2: A 4 kHz tick causes counter reads of cards 0 through 5 in ascending order.
- R3: A 1 kHz tick causes counter reads of cards 0 through 8 in ascending order.
- R4: On a counter read, wide equals bit card_id of the CARD_WIDE parameter, where 1 means a 32-bit read. On a status read, wide is 0.
- R5: sync is 1 on exactly one read: the first read granted after a 1 kHz readout completes. It is 0 on every other read.
- R6: Ticks that arrive in the same cycle are serviced once, as the most inclusive set among them.
- R7: After every LK_PER_CYCLE-th 1 kHz readout, twelve status reads (reg_sel=1) follow at once. They cover cards 0..8 and then 0, 1, 2, and no tick readout runs in between.
- R8: A tick that arrives while a readout runs is kept pending and serviced afterwards. Several pending ticks merge into the most inclusive one.
- R9: While busy is 1, req is 0 and the readout keeps its position. When busy returns to 0, the readout resumes where it stopped.
- R10: While en is 0, req is 0 and ticks are ignored. A tick seen while disabled produces no reads after en returns to 1.
- R11: While req is 1 and grant is 0, card_id, reg_sel and wide stay unchanged. Each cycle with req and grant both 1 completes one read.
- R12: xfer_type is always 1, the rate-data type code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Collection enable |
| busy | input | 1 | Downstream busy, pauses requests |
| tick_16k | input | 1 | 16 kHz timing tick, one-cycle pulse |
| tick_4k | input | 1 | 4 kHz timing tick, one-cycle pulse |
| tick_1k | input | 1 | 1 kHz timing tick, one-cycle pulse |
| grant | input | 1 | Arbiter accepts the current request this cycle |
| req | output | 1 | Bus cycle request |
| card_id | output | 4 | Card to read |
| reg_sel | output | 1 | 0 = rate counter, 1 = status register |
| wide | output | 1 | 1 = 32-bit read, 0 = 16-bit read |
| sync | output | 1 | Sync marker for the packet formatter |
| xfer_type | output | 2 | Transfer type code for the packet formatter |

## Verification
The bench drives a 16 kHz and a 1 kHz tick in the same cycle. A design that merged them wrongly would issue twelve reads, or only three, instead of nine. It then checks the status run that follows the second 1 kHz readout. Here a wrong index map shows up as cards 9 to 11, or as counter reads, and a misplaced sync lands on the tick reads instead of the first status read. It stacks 4 kHz and 16 kHz ticks during a stalled readout. A design without pending capture would drop the second set, and one that kept only the latest tick would read three cards where six are due. Busy and enable tests show whether a design leaks requests while paused, or carries a tick seen while disabled into later reads.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int ID_W = 4;
    localparam logic [1:0] XTYPE_RATE = 2'd1;

    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_16K  = 2'd1,
        LV_4K   = 2'd2,
        LV_1K   = 2'd3
    } lvl_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_TICK = 2'd1,
        PH_STAT = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ID_W-1:0] card;
        logic            stat;
        logic            wide;
    } rd_t;

    function automatic lvl_e lvl_max(lvl_e a, lvl_e b);
        return (a > b) ? a : b;
    endfunction

    function automatic lvl_e lvl_of(logic t16, logic t4, logic t1);
        if (t1)       return LV_1K;
        else if (t4)  return LV_4K;
        else if (t16) return LV_16K;
        else          return LV_NONE;
    endfunction

endpackage

// File: rtl/rrs_tick_latch.sv
module rrs_tick_latch
    import rrs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick_16k,
    input  logic tick_4k,
    input  logic tick_1k,
    input  logic take,
    output lvl_e pend
);

    lvl_e incoming;

    always_comb begin
        incoming = lvl_of(tick_16k, tick_4k, tick_1k);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pend <= LV_NONE;
        end else if (take) begin
            pend <= incoming;
        end else begin
            pend <= lvl_max(pend, incoming);
        end
    end

    // R6: coincident ticks keep the widest set
    a_r6_widest_wins: assert property (@(posedge clk) disable iff (rst)
        (en && tick_1k && tick_16k) |=> (pend == LV_1K));

    // R8: a pending full readout is not lost before it is taken
    a_r8_pending_kept: assert property (@(posedge clk) disable iff (rst)
        (en && !take && pend == LV_1K) |=> (pend == LV_1K));

endmodule

// File: rtl/rrs_seq_fsm.sv
module rrs_seq_fsm
    import rrs_pkg::*;
#(
    parameter int              N_CARDS      = 9,
    parameter int              SET_A        = 3,
    parameter int              SET_B        = 6,
    parameter int              LK_PER_CYCLE = 2,
    parameter logic [N_CARDS-1:0] CARD_WIDE = 9'b000000111
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic busy,
    input  logic grant,
    input  lvl_e pend,
    output logic take,
    output logic req,
    output rd_t  rd,
    output logic sync
);

    localparam int STAT_LEN = N_CARDS + SET_A;
    localparam int IDX_W    = $clog2(STAT_LEN + 1);
    localparam int LK_W     = $clog2(LK_PER_CYCLE + 1);

    phase_e           phase;
    lvl_e             lvl;
    logic [IDX_W-1:0] idx;
    logic [LK_W-1:0]  lk_cnt;
    logic             sync_due;

    logic [IDX_W-1:0] cur_len;
    logic             last;
    logic             fire;

    always_comb begin
        case (lvl)
            LV_16K:  cur_len = IDX_W'(SET_A);
            LV_4K:   cur_len = IDX_W'(SET_B);
            LV_1K:   cur_len = IDX_W'(N_CARDS);
            default: cur_len = '0;
        endcase
    end

    always_comb begin
        rd = '0;
        if (phase == PH_STAT) begin
            rd.stat = 1'b1;
            rd.wide = 1'b0;
            if (idx < IDX_W'(N_CARDS))
                rd.card = ID_W'(idx);
            else
                rd.card = ID_W'(idx - IDX_W'(N_CARDS));
            last = (idx == IDX_W'(STAT_LEN - 1));
        end else begin
            rd.stat = 1'b0;
            rd.card = ID_W'(idx);
            rd.wide = CARD_WIDE[rd.card];
            last    = (idx == cur_len - IDX_W'(1));
        end
    end

    always_comb begin
        req  = en && !busy && (phase != PH_IDLE);
        take = en && (phase == PH_IDLE) && (pend != LV_NONE);
        fire = req && grant;
        sync = req && sync_due;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase    <= PH_IDLE;
            lvl      <= LV_NONE;
            idx      <= '0;
            lk_cnt   <= '0;
            sync_due <= 1'b0;
        end else if (take) begin
            phase <= PH_TICK;
            lvl   <= pend;
            idx   <= '0;
        end else if (fire) begin
            sync_due <= 1'b0;
            if (last) begin
                idx <= '0;
                if (phase == PH_TICK && lvl == LV_1K) begin
                    sync_due <= 1'b1;
                    if (lk_cnt == LK_W'(LK_PER_CYCLE - 1)) begin
                        lk_cnt <= '0;
                        phase  <= PH_STAT;
                    end else begin
                        lk_cnt <= lk_cnt + LK_W'(1);
                        phase  <= PH_IDLE;
                    end
                end else begin
                    phase <= PH_IDLE;
                end
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // R11: an unanswered request keeps its read descriptor
    a_r11_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |=> ($stable(rd.card) && $stable(rd.stat)));

    // R10: disabling ends all requests on the next cycle
    a_r10_disable_quiets: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> !req);

    // R5: the sync marker rides on a single read
    a_r5_sync_once: assert property (@(posedge clk) disable iff (rst)
        (sync && grant) |=> !sync);

    // R7: status reads only address real cards
    a_r7_stat_in_range: assert property (@(posedge clk) disable iff (rst)
        (req && rd.stat) |-> (rd.card < ID_W'(N_CARDS)));

endmodule

// File: rtl/rate_readout_seq.sv
module rate_readout_seq
    import rrs_pkg::*;
#(
    parameter int              N_CARDS      = 9,
    parameter int              SET_A        = 3,
    parameter int              SET_B        = 6,
    parameter int              LK_PER_CYCLE = 2,
    parameter logic [N_CARDS-1:0] CARD_WIDE = 9'b000000111
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       busy,
    input  logic       tick_16k,
    input  logic       tick_4k,
    input  logic       tick_1k,
    input  logic       grant,
    output logic       req,
    output logic [3:0] card_id,
    output logic       reg_sel,
    output logic       wide,
    output logic       sync,
    output logic [1:0] xfer_type
);

    lvl_e pend;
    logic take;
    rd_t  rd;

    rrs_tick_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick_16k (tick_16k),
        .tick_4k  (tick_4k),
        .tick_1k  (tick_1k),
        .take     (take),
        .pend     (pend)
    );

    rrs_seq_fsm #(
        .N_CARDS      (N_CARDS),
        .SET_A        (SET_A),
        .SET_B        (SET_B),
        .LK_PER_CYCLE (LK_PER_CYCLE),
        .CARD_WIDE    (CARD_WIDE)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .busy  (busy),
        .grant (grant),
        .pend  (pend),
        .take  (take),
        .req   (req),
        .rd    (rd),
        .sync  (sync)
    );

    assign card_id   = rd.card;
    assign reg_sel   = rd.stat;
    assign wide      = rd.wide;
    assign xfer_type = XTYPE_RATE;

endmodule

// File: tb/sim_rate_readout_seq.sv
`timescale 1ns/1ps
module sim_rate_readout_seq;

    localparam logic [8:0] CW = 9'b000000111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1, busy = 1'b0;
    logic t16 = 1'b0, t4 = 1'b0, t1 = 1'b0;
    logic grant = 1'b0;
    logic req, reg_sel, wide, sync;
    logic [3:0] card_id;
    logic [1:0] xfer_type;

    int n_chk = 0, n_fail = 0;
    bit auto_gnt = 1'b1;
    int lcount = 0;
    int l_card [0:63];
    int l_st [0:63];
    int l_wd [0:63];
    int l_sy [0:63];

    always #5 clk = ~clk;

    rate_readout_seq u0 (
        .clk(clk), .rst(rst), .en(en), .busy(busy),
        .tick_16k(t16), .tick_4k(t4), .tick_1k(t1), .grant(grant),
        .req(req), .card_id(card_id), .reg_sel(reg_sel), .wide(wide),
        .sync(sync), .xfer_type(xfer_type)
    );

    always @(negedge clk) begin
        if (!rst && auto_gnt && req) begin
            if (lcount < 64) begin
                l_card[lcount] = int'(card_id);
                l_st[lcount]   = int'(reg_sel);
                l_wd[lcount]   = int'(wide);
                l_sy[lcount]   = int'(sync);
            end
            lcount = lcount + 1;
            grant = 1'b1;
        end else begin
            grant = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input bit a, input bit b, input bit c);
        @(negedge clk); t16 = a; t4 = b; t1 = c;
        @(negedge clk); t16 = 0; t4 = 0; t1 = 0;
    endtask

    task automatic wait_reads(input int n, input string tag);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (lcount >= n) break;
        end
        repeat (6) @(negedge clk);
        chk(lcount == n, {tag, " read count"}, lcount, n);
    endtask

    task automatic chk_tick(input int base, input int card, input int sy, input string tag);
        chk(l_card[base] == card, {tag, " card"}, l_card[base], card);
        chk(l_st[base] == 0, {tag, " reg_sel"}, l_st[base], 0);
        chk(l_wd[base] == int'(CW[card]), "R4 width", l_wd[base], int'(CW[card]));
        chk(l_sy[base] == sy, "R5 sync", l_sy[base], sy);
    endtask

    task automatic run_set(input bit a, input bit b, input bit c, input int n,
                           input int first_sy, input string tag);
        lcount = 0;
        pulse(a, b, c);
        wait_reads(n, tag);
        for (int i = 0; i < n; i++) chk_tick(i, i, (i == 0) ? first_sy : 0, tag);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req == 0, "R11 reset req", int'(req), 0);
        chk(sync == 0, "R5 reset sync", int'(sync), 0);
        chk(xfer_type == 2'd1, "R12 type code", int'(xfer_type), 1);
    endtask

    task automatic t_basic_sets;
        run_set(1, 0, 0, 3, 0, "R1");
        run_set(0, 1, 0, 6, 0, "R2");
        run_set(0, 0, 1, 9, 0, "R3");
        run_set(1, 0, 0, 3, 1, "R5 after 1k");
    endtask

    task automatic t_coincide_and_status;
        lcount = 0;
        pulse(1, 0, 1);
        wait_reads(21, "R6 R7");
        for (int i = 0; i < 9; i++) chk_tick(i, i, 0, "R6");
        for (int i = 0; i < 12; i++) begin
            int ec;
            ec = (i < 9) ? i : i - 9;
            chk(l_card[9+i] == ec, "R7 status card", l_card[9+i], ec);
            chk(l_st[9+i] == 1, "R7 status reg_sel", l_st[9+i], 1);
            chk(l_wd[9+i] == 0, "R4 status width", l_wd[9+i], 0);
            chk(l_sy[9+i] == ((i == 0) ? 1 : 0), "R5 sync on status", l_sy[9+i], (i == 0) ? 1 : 0);
        end
        run_set(1, 0, 0, 3, 0, "R5 no repeat");
    endtask

    task automatic t_pending_hold;
        int c0;
        auto_gnt = 0;
        lcount = 0;
        pulse(1, 0, 0);
        repeat (3) @(negedge clk);
        chk(req == 1, "R11 req held", int'(req), 1);
        c0 = int'(card_id);
        pulse(0, 1, 0);
        pulse(1, 0, 0);
        chk(req == 1 && int'(card_id) == c0, "R11 stable card", int'(card_id), c0);
        auto_gnt = 1;
        wait_reads(9, "R8");
        for (int i = 0; i < 3; i++) chk_tick(i, i, 0, "R8 first");
        for (int i = 0; i < 6; i++) chk_tick(3 + i, i, 0, "R8 merged");
    endtask

    task automatic t_busy;
        lcount = 0;
        @(negedge clk); busy = 1;
        pulse(1, 0, 0);
        repeat (5) @(negedge clk);
        chk(req == 0, "R9 req during busy", int'(req), 0);
        chk(lcount == 0, "R9 no reads during busy", lcount, 0);
        busy = 0;
        wait_reads(3, "R9");
        for (int i = 0; i < 3; i++) chk_tick(i, i, 0, "R9");
    endtask

    task automatic t_enable;
        lcount = 0;
        @(negedge clk); en = 0;
        pulse(0, 0, 1);
        repeat (3) @(negedge clk);
        chk(req == 0, "R10 req while off", int'(req), 0);
        en = 1;
        repeat (8) @(negedge clk);
        chk(lcount == 0, "R10 tick ignored", lcount, 0);
        run_set(0, 1, 0, 6, 0, "R10 after enable");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_basic_sets();
        t_coincide_and_status();
        t_pending_hold();
        t_busy();
        t_enable();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule